// File: doc/BRIEF.md
# Jacobian Point Adder

This block adds two elliptic-curve points, both held in projective Jacobian form, over a prime field whose modulus is a parameter. The user writes the six coordinates through a single load port and pulses `start`. The block then steps through a fixed program of twenty-three modular operations on one shared ALU. The ALU does single-cycle addition and subtraction and a bit-serial multiplier. The sum appears on three result outputs, followed by a one-cycle `done` pulse.

The block is meant for a scalar-multiplication ladder in which the two running points always differ by the base point. For that reason it never compares the operands with each other, and the equal-point and opposite-point cases are not handled. The only special cases it recognises are operands at infinity, meaning a Z coordinate of zero. It tests both Z coordinates when `start` is accepted. The full program always runs, and the infinity override is applied only when the result registers are written, so every operation takes the same number of cycles.

The controller has five states:
- `ST_IDLE` accepts loads and `start`.
- `ST_ISSUE` sends one micro-operation to the ALU.
- `ST_WAIT` waits for the ALU and writes its result back, then returns to `ST_ISSUE` or, after the last micro-operation, moves to `ST_SELECT`.
- `ST_SELECT` writes the chosen result into the output registers.
- `ST_DONE` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `jacobian_point_adder`

## Requirements
- R1: After reset, `r_x`, `r_y` and `r_z` are zero and both `busy` and `done` are low.
- R2: When neither Z input is zero, the block computes R = P + Q modulo MODULUS using this sequence. It forms the cross-scaled terms a = Px·Qz², b = Qx·Pz², c = Py·Qz³ and d = Qy·Pz³, then h = b − a and s = d − c. The result is rz = h·Pz·Qz, rx = s² − h³ − 2·a·h², and ry = s·(a·h² − rx) − c·h³. All inputs must be below MODULUS.
- R3: If Pz is zero, the result equals the Q operand exactly.
- R4: If Pz is nonzero and Qz is zero, the result equals the P operand exactly.
- R5: If both Z inputs are zero, the P-at-infinity rule wins and the result is Q.
- R6: `done` is high in the cycle after the 16·(WIDTH+2)+15-th rising edge, counted from the edge that samples `start`. This count does not depend on the operand values or the infinity cases.
- R7: `done` is high for exactly one cycle, and `busy` is low in the cycle after it.
- R8: A `start` pulse while `busy` is high has no effect: the running operation keeps its latency and result, and no second operation follows.
- R9: Load-port writes are ignored while `busy` is high. The load port selects a coordinate with `ld_sel`: 0 Px, 1 Py, 2 Pz, 3 Qx, 4 Qy, 5 Qz. Codes 6 and 7 write nothing.
- R10: `r_x`, `r_y` and `r_z` change only on the edge that begins the `done` cycle. They hold their values between operations, including while new operands are loaded.
- R11: Equal operands are not detected. For P = Q with nonzero Z, the result follows the R2 formula, which gives rz = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an addition; accepted only while idle |
| ld_en | input | 1 | Write `ld_data` into the coordinate chosen by `ld_sel` |
| ld_sel | input | 3 | Coordinate select: 0 Px, 1 Py, 2 Pz, 3 Qx, 4 Qy, 5 Qz |
| ld_data | input | WIDTH | Coordinate value, below MODULUS |
| busy | output | 1 | High from the cycle after `start` through the `done` cycle |
| done | output | 1 | One-cycle completion pulse |
| r_x | output | WIDTH | Result X coordinate |
| r_y | output | WIDTH | Result Y coordinate |
| r_z | output | WIDTH | Result Z coordinate |

## Verification
A micro-operation that reads or writes the wrong temporary does not show up during the run. It appears only as wrong `r_x`/`r_y`/`r_z` values in the `done` cycle, which is at least a full program length after `start`. Each result must therefore be compared against values computed independently from the formula. A fault in the program counter or in the state machine changes the cycle on which `done` arrives, so an exact latency count catches it on the first operation. A fault in the infinity selection only shows on operands with a zero Z coordinate. Those cases, including the case where both Z coordinates are zero, get their own directed runs.

// File: rtl/jpa_pkg.sv
package jpa_pkg;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_MUL = 2'd2
    } alu_op_e;

    localparam int REG_COUNT = 17;
    localparam int IDX_W     = $clog2(REG_COUNT);
    typedef logic [IDX_W-1:0] reg_idx_t;

    // operand storage map
    localparam reg_idx_t IX_PX = 5'd0;
    localparam reg_idx_t IX_PY = 5'd1;
    localparam reg_idx_t IX_PZ = 5'd2;
    localparam reg_idx_t IX_QX = 5'd3;
    localparam reg_idx_t IX_QY = 5'd4;
    localparam reg_idx_t IX_QZ = 5'd5;
    localparam reg_idx_t IX_T1 = 5'd6;
    localparam reg_idx_t IX_T2 = 5'd7;
    localparam reg_idx_t IX_T3 = 5'd8;
    localparam reg_idx_t IX_T4 = 5'd9;
    localparam reg_idx_t IX_T5 = 5'd10;
    localparam reg_idx_t IX_T6 = 5'd11;
    localparam reg_idx_t IX_T7 = 5'd12;
    localparam reg_idx_t IX_T8 = 5'd13;
    localparam reg_idx_t IX_WX = 5'd14;
    localparam reg_idx_t IX_WY = 5'd15;
    localparam reg_idx_t IX_WZ = 5'd16;

    localparam int LOAD_SLOTS = 6;

    typedef struct packed {
        alu_op_e  op;
        reg_idx_t src_a;
        reg_idx_t src_b;
        reg_idx_t dst;
    } uop_t;

    localparam int PROG_LEN = 23;
    localparam int PC_W     = $clog2(PROG_LEN);
    typedef logic [PC_W-1:0] pc_t;

    function automatic uop_t mk(input alu_op_e o, input reg_idx_t a,
                                input reg_idx_t b, input reg_idx_t d);
        uop_t u;
        u.op    = o;
        u.src_a = a;
        u.src_b = b;
        u.dst   = d;
        return u;
    endfunction

    // fixed addition program; order matters because temporaries are reused
    function automatic uop_t uop_at(input pc_t pc);
        unique case (pc)
            5'd0:  return mk(ALU_MUL, IX_PZ, IX_PZ, IX_T1);
            5'd1:  return mk(ALU_MUL, IX_QZ, IX_QZ, IX_T2);
            5'd2:  return mk(ALU_MUL, IX_PZ, IX_T1, IX_T3);
            5'd3:  return mk(ALU_MUL, IX_QZ, IX_T2, IX_T4);
            5'd4:  return mk(ALU_MUL, IX_PX, IX_T2, IX_T5);
            5'd5:  return mk(ALU_MUL, IX_QX, IX_T1, IX_T2);
            5'd6:  return mk(ALU_MUL, IX_PY, IX_T4, IX_T6);
            5'd7:  return mk(ALU_MUL, IX_QY, IX_T3, IX_T4);
            5'd8:  return mk(ALU_SUB, IX_T2, IX_T5, IX_T7);
            5'd9:  return mk(ALU_SUB, IX_T4, IX_T6, IX_T8);
            5'd10: return mk(ALU_MUL, IX_PZ, IX_QZ, IX_T1);
            5'd11: return mk(ALU_MUL, IX_T7, IX_T1, IX_WZ);
            5'd12: return mk(ALU_MUL, IX_T8, IX_T8, IX_T2);
            5'd13: return mk(ALU_MUL, IX_T7, IX_T7, IX_T3);
            5'd14: return mk(ALU_MUL, IX_T7, IX_T3, IX_T4);
            5'd15: return mk(ALU_SUB, IX_T2, IX_T4, IX_T1);
            5'd16: return mk(ALU_MUL, IX_T5, IX_T3, IX_T2);
            5'd17: return mk(ALU_ADD, IX_T2, IX_T2, IX_T3);
            5'd18: return mk(ALU_SUB, IX_T1, IX_T3, IX_WX);
            5'd19: return mk(ALU_SUB, IX_T2, IX_WX, IX_T1);
            5'd20: return mk(ALU_MUL, IX_T1, IX_T8, IX_T2);
            5'd21: return mk(ALU_MUL, IX_T6, IX_T4, IX_T3);
            5'd22: return mk(ALU_SUB, IX_T2, IX_T3, IX_WY);
            default: return mk(ALU_ADD, IX_T1, IX_T1, IX_T1);
        endcase
    endfunction

endpackage

// File: rtl/jpa_ucode.sv
module jpa_ucode
    import jpa_pkg::*;
(
    input  pc_t  pc,
    output uop_t uop
);
    always_comb begin
        uop = uop_at(pc);
    end
endmodule

// File: rtl/jpa_regfile.sv
module jpa_regfile
    import jpa_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  reg_idx_t         widx,
    input  logic [WIDTH-1:0] wdata,
    input  reg_idx_t         ra_idx,
    input  reg_idx_t         rb_idx,
    output logic [WIDTH-1:0] ra_data,
    output logic [WIDTH-1:0] rb_data,
    output logic [WIDTH-1:0] regs_o [REG_COUNT]
);
    logic [WIDTH-1:0] store [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                store[g] <= '0;
            end else if (we && (widx == reg_idx_t'(g))) begin
                store[g] <= wdata;
            end
        end
        assign regs_o[g] = store[g];
    end

    always_comb begin
        ra_data = '0;
        rb_data = '0;
        if (int'(ra_idx) < REG_COUNT) ra_data = store[ra_idx];
        if (int'(rb_idx) < REG_COUNT) rb_data = store[rb_idx];
    end
endmodule

// File: rtl/jpa_modalu.sv
module jpa_modalu
    import jpa_pkg::*;
#(
    parameter int               WIDTH   = 16,
    parameter logic [WIDTH-1:0] MODULUS = 16'd65521
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             done,
    output logic [WIDTH-1:0] result
);
    localparam int          CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [WIDTH:0] MOD_EXT = {1'b0, MODULUS};

    function automatic logic [WIDTH-1:0] add_mod(input logic [WIDTH-1:0] x,
                                                 input logic [WIDTH-1:0] y);
        logic [WIDTH:0] s;
        s = {1'b0, x} + {1'b0, y};
        if (s >= MOD_EXT) s = s - MOD_EXT;
        return s[WIDTH-1:0];
    endfunction

    function automatic logic [WIDTH-1:0] sub_mod(input logic [WIDTH-1:0] x,
                                                 input logic [WIDTH-1:0] y);
        logic [WIDTH:0] d;
        d = {1'b0, x} - {1'b0, y};
        if (x < y) d = d + MOD_EXT;
        return d[WIDTH-1:0];
    endfunction

    logic             mul_run;
    logic [CNT_W-1:0] mul_cnt;
    logic [WIDTH-1:0] mul_acc;
    logic [WIDTH-1:0] mul_mcand;
    logic [WIDTH-1:0] mul_bits;
    logic [WIDTH-1:0] step_val;

    // one MSB-first double-and-add step
    always_comb begin
        logic [WIDTH-1:0] dbl;
        dbl      = add_mod(mul_acc, mul_acc);
        step_val = mul_bits[WIDTH-1] ? add_mod(dbl, mul_mcand) : dbl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mul_run   <= 1'b0;
            mul_cnt   <= '0;
            mul_acc   <= '0;
            mul_mcand <= '0;
            mul_bits  <= '0;
            result    <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !mul_run) begin
                unique case (op)
                    ALU_ADD: begin
                        result <= add_mod(a, b);
                        done   <= 1'b1;
                    end
                    ALU_SUB: begin
                        result <= sub_mod(a, b);
                        done   <= 1'b1;
                    end
                    default: begin
                        mul_run   <= 1'b1;
                        mul_cnt   <= CNT_W'(WIDTH - 1);
                        mul_acc   <= '0;
                        mul_mcand <= a;
                        mul_bits  <= b;
                    end
                endcase
            end else if (mul_run) begin
                mul_acc  <= step_val;
                mul_bits <= {mul_bits[WIDTH-2:0], 1'b0};
                mul_cnt  <= mul_cnt - 1'b1;
                if (mul_cnt == '0) begin
                    mul_run <= 1'b0;
                    result  <= step_val;
                    done    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/jacobian_point_adder.sv
module jacobian_point_adder
    import jpa_pkg::*;
#(
    parameter int               WIDTH   = 16,
    parameter logic [WIDTH-1:0] MODULUS = 16'd65521
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ld_en,
    input  logic [2:0]       ld_sel,
    input  logic [WIDTH-1:0] ld_data,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] r_x,
    output logic [WIDTH-1:0] r_y,
    output logic [WIDTH-1:0] r_z
);
    localparam pc_t LAST_PC = pc_t'(PROG_LEN - 1);

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ISSUE  = 3'd1,
        ST_WAIT   = 3'd2,
        ST_SELECT = 3'd3,
        ST_DONE   = 3'd4
    } state_e;

    state_e           state, state_nx;
    pc_t              pc;
    uop_t             uop;
    logic             pz_inf, qz_inf;

    logic             rf_we;
    reg_idx_t         rf_widx;
    logic [WIDTH-1:0] rf_wdata;
    logic [WIDTH-1:0] opa, opb;
    logic [WIDTH-1:0] regs [REG_COUNT];

    logic             alu_start, alu_done;
    logic [WIDTH-1:0] alu_res;

    jpa_ucode u_ucode (
        .pc  (pc),
        .uop (uop)
    );

    jpa_regfile #(.WIDTH(WIDTH)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .widx    (rf_widx),
        .wdata   (rf_wdata),
        .ra_idx  (uop.src_a),
        .rb_idx  (uop.src_b),
        .ra_data (opa),
        .rb_data (opb),
        .regs_o  (regs)
    );

    jpa_modalu #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_alu (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (alu_start),
        .op     (uop.op),
        .a      (opa),
        .b      (opb),
        .done   (alu_done),
        .result (alu_res)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_ISSUE;
            ST_ISSUE:  state_nx = ST_WAIT;
            ST_WAIT:   if (alu_done) state_nx = (pc == LAST_PC) ? ST_SELECT : ST_ISSUE;
            ST_SELECT: state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // combinational strobes and write port steering
    always_comb begin
        alu_start = (state == ST_ISSUE);
        rf_we     = 1'b0;
        rf_widx   = uop.dst;
        rf_wdata  = alu_res;
        if (state == ST_IDLE) begin
            rf_we    = ld_en && (int'(ld_sel) < LOAD_SLOTS);
            rf_widx  = reg_idx_t'(ld_sel);
            rf_wdata = ld_data;
        end else if (state == ST_WAIT) begin
            rf_we = alu_done;
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);

    // outputs and sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc     <= '0;
            pz_inf <= 1'b0;
            qz_inf <= 1'b0;
            r_x    <= '0;
            r_y    <= '0;
            r_z    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pc     <= '0;
                        pz_inf <= (regs[IX_PZ] == '0);
                        qz_inf <= (regs[IX_QZ] == '0);
                    end
                end
                ST_WAIT: begin
                    if (alu_done && pc != LAST_PC) pc <= pc + 1'b1;
                end
                ST_SELECT: begin
                    if (pz_inf) begin
                        r_x <= regs[IX_QX];
                        r_y <= regs[IX_QY];
                        r_z <= regs[IX_QZ];
                    end else if (qz_inf) begin
                        r_x <= regs[IX_PX];
                        r_y <= regs[IX_PY];
                        r_z <= regs[IX_PZ];
                    end else begin
                        r_x <= regs[IX_WX];
                        r_y <= regs[IX_WY];
                        r_z <= regs[IX_WZ];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/jpa_checker.sv
module jpa_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] r_x,
    input logic [WIDTH-1:0] r_y,
    input logic [WIDTH-1:0] r_z
);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r1_no_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !done);

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(r_x) && $stable(r_y) && $stable(r_z)));
endmodule

bind jacobian_point_adder jpa_checker #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .r_x   (r_x),
    .r_y   (r_y),
    .r_z   (r_z)
);

// File: tb/jacobian_point_adder_tb.sv
module jacobian_point_adder_tb;
    localparam int    W   = 16;
    localparam longint M  = 65521;
    localparam int    LAT = 16 * (W + 2) + 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         ld_en = 1'b0;
    logic [2:0]   ld_sel = '0;
    logic [W-1:0] ld_data = '0;
    logic         busy, done;
    logic [W-1:0] r_x, r_y, r_z;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    jacobian_point_adder u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ld_en(ld_en),
        .ld_sel(ld_sel), .ld_data(ld_data), .busy(busy), .done(done),
        .r_x(r_x), .r_y(r_y), .r_z(r_z)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint mm(input longint a, input longint b);
        return (a * b) % M;
    endfunction
    function automatic longint ms(input longint a, input longint b);
        return (a + M - b) % M;
    endfunction

    // expected sum from the R2 formula plus the R3/R4/R5 selection
    task automatic model(input longint px, py, pz, qx, qy, qz,
                         output longint ex, ey, ez);
        longint a, b, c, d, h, s, h2, h3;
        if (pz == 0) begin ex = qx; ey = qy; ez = qz; return; end
        if (qz == 0) begin ex = px; ey = py; ez = pz; return; end
        a  = mm(px, mm(qz, qz));
        b  = mm(qx, mm(pz, pz));
        c  = mm(py, mm(qz, mm(qz, qz)));
        d  = mm(qy, mm(pz, mm(pz, pz)));
        h  = ms(b, a);
        s  = ms(d, c);
        h2 = mm(h, h);
        h3 = mm(h, h2);
        ez = mm(h, mm(pz, qz));
        ex = ms(ms(mm(s, s), h3), (2 * mm(a, h2)) % M);
        ey = ms(mm(s, ms(mm(a, h2), ex)), mm(c, h3));
    endtask

    task automatic load(input int sel, input longint v);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 3'(sel); ld_data = W'(v);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load_all(input longint px, py, pz, qx, qy, qz);
        load(0, px); load(1, py); load(2, pz);
        load(3, qx); load(4, qy); load(5, qz);
    endtask

    // pulse start, count edges to done; optional extra start/load mid-run
    task automatic run(output int lat, input int poke_at, input bit poke_start,
                       input bit poke_load);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        lat = 0;
        while (lat < 4000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == poke_at) begin
                if (poke_start) start = 1'b1;
                if (poke_load) begin ld_en = 1'b1; ld_sel = 3'd0; ld_data = 16'd777; end
            end else begin
                start = 1'b0; ld_en = 1'b0;
            end
            if (done) break;
        end
        start = 1'b0; ld_en = 1'b0;
    endtask

    task automatic add_case(input string req, input longint px, py, pz, qx, qy, qz);
        longint ex, ey, ez;
        int lat;
        load_all(px, py, pz, qx, qy, qz);
        model(px, py, pz, qx, qy, qz, ex, ey, ez);
        run(lat, -1, 1'b0, 1'b0);
        chk({req, " rx"}, longint'(r_x), ex);
        chk({req, " ry"}, longint'(r_y), ey);
        chk({req, " rz"}, longint'(r_z), ez);
        chk({req, " R6 latency"}, lat, LAT);
        @(negedge clk);
        chk({req, " R7 done width"}, longint'(done), 0);
        chk({req, " R7 busy after done"}, longint'(busy), 0);
    endtask

    task automatic t_reset;
        chk("R1 r_x", longint'(r_x), 0);
        chk("R1 r_y", longint'(r_y), 0);
        chk("R1 r_z", longint'(r_z), 0);
        chk("R1 busy", longint'(busy), 0);
        chk("R1 done", longint'(done), 0);
    endtask

    task automatic t_start_busy;
        longint ex, ey, ez;
        int lat;
        load_all(11, 22, 33, 44, 55, 66);
        model(11, 22, 33, 44, 55, 66, ex, ey, ez);
        run(lat, 40, 1'b1, 1'b0);
        chk("R8 latency with stray start", lat, LAT);
        chk("R8 rx", longint'(r_x), ex);
        repeat (3) @(negedge clk);
        chk("R8 no second run", longint'(busy), 0);
    endtask

    task automatic t_load_busy;
        longint ex, ey, ez;
        int lat;
        load_all(1234, 4321, 999, 8888, 7777, 31);
        model(1234, 4321, 999, 8888, 7777, 31, ex, ey, ez);
        run(lat, 60, 1'b0, 1'b1);
        chk("R9 rx with load during run", longint'(r_x), ex);
        run(lat, -1, 1'b0, 1'b0);
        chk("R9 Px unchanged rx", longint'(r_x), ex);
        chk("R9 Px unchanged ry", longint'(r_y), ey);
        load(6, 5); load(7, 5);
        run(lat, -1, 1'b0, 1'b0);
        chk("R9 codes 6/7 write nothing", longint'(r_z), ez);
    endtask

    task automatic t_hold;
        logic [W-1:0] hx, hy, hz;
        hx = r_x; hy = r_y; hz = r_z;
        load_all(5, 6, 7, 8, 9, 10);
        repeat (20) @(negedge clk);
        chk("R10 r_x held", longint'(r_x), longint'(hx));
        chk("R10 r_y held", longint'(r_y), longint'(hy));
        chk("R10 r_z held", longint'(r_z), longint'(hz));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        add_case("R2 pattern A", 3, 5, 7, 11, 13, 17);
        add_case("R2 pattern B", 65520, 65519, 65518, 1, 2, 3);
        add_case("R2 pattern C", 40000, 12345, 1, 23456, 54321, 1);
        add_case("R3 P at infinity", 100, 200, 0, 300, 400, 500);
        add_case("R4 Q at infinity", 101, 202, 303, 404, 505, 0);
        add_case("R5 both at infinity", 1, 1, 0, 9, 8, 0);
        add_case("R11 equal points", 4242, 1717, 29, 4242, 1717, 29);
        t_hold();
        t_start_busy();
        t_load_busy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule